// File: doc/BRIEF.md
# Signaling Frame Classifier

This block watches a frame sync line, one sample per bit clock, and sorts each frame into one of two kinds. A pulse that is high for a single bit period marks an ordinary voice frame. A pulse held high for two or more bit periods marks a frame that carries channel-associated signaling. One instance serves each channel side of a dual-channel ADPCM codec.

The block reads the configured algorithm code once per frame, when the pulse begins, and holds that value until the next frame. It then drives the algorithm that the codec should use for the frame. For a signaling frame on the 32 kbit/s setting, the output is forced to the 24 kbit/s algorithm. This leaves the least significant ADPCM bit free for signaling, which logic outside the block inserts. A signaling flag reports the frame type and stays valid until the next frame begins.

The module clock is the bit clock, on the edge where frame sync is sampled. The integrator connects an inverted bit clock so that samples land on falling edges. Because the configuration is latched afresh at every frame start, a rate change applies from the next frame and needs no reset.

Top module: `cas_frame_classifier`

## Requirements
- R1: After reset the effective algorithm output is 000 (32 kbit/s) and the signaling flag is 0.
- R2: A frame whose sync is sampled high for only one clock leaves the signaling flag at 0 for the whole frame.
- R3: The signaling flag goes to 1 on the clock edge that samples frame sync high for the second consecutive time.
- R4: The signaling flag goes back to 0 on the edge that samples the start of the next pulse (sync high after a low sample), and that frame is then classified again on its own width.
- R5: The configured code is captured on the edge that samples the start of a pulse. Changes to the configuration input between pulse starts do not change the effective output until the next pulse start.
- R6: While the signaling flag is 1 and the captured code means 32 kbit/s, the effective output is 111 (24 kbit/s).
- R7: When the captured code is 111 (24 kbit/s) or 101 (16 kbit/s), the effective output equals that code whatever the width of the pulse. The flag still reports a wide pulse.
- R8: A captured code other than 000, 111 or 101 is treated as 000 (32 kbit/s), including the forcing to 111 on signaling frames. The effective output only ever takes the values 000, 111 or 101.
- R9: A pulse of three or more clocks is classified the same way as a two-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, active on the sampling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync line |
| cfg_alg | input | 3 | Configured algorithm code |
| eff_alg | output | 3 | Algorithm to apply for the current frame |
| sig_frame | output | 1 | 1 while the current frame is a signaling frame |

## Verification
The bench uses the default threshold of two clocks and the default codes 000, 111 and 101. With these values, pulses of one, two and three clocks fall on both sides of the threshold and also exercise counter saturation. Frames run sixteen clocks apart, which leaves room to change the configuration in the middle of a frame. Each frame type is driven with each configured code, including an undefined code, and the outputs are compared on every clock with a behavioural model.

// File: rtl/cas_frame_classifier.sv
module cas_frame_classifier #(
  parameter int          ALG_W    = 3,
  parameter int          MIN_WIDE = 2,
  parameter logic [2:0]  CODE_32K = 3'b000,
  parameter logic [2:0]  CODE_24K = 3'b111,
  parameter logic [2:0]  CODE_16K = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [ALG_W-1:0] cfg_alg,
  output logic [ALG_W-1:0] eff_alg,
  output logic             sig_frame
);
  localparam int CNT_W = $clog2(MIN_WIDE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_WIDE);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(MIN_WIDE - 1);

  logic             fs_q;
  logic [CNT_W-1:0] hi_cnt;
  logic [ALG_W-1:0] cfg_q;
  logic [ALG_W-1:0] cfg_norm;
  logic             pulse_start;

  assign pulse_start = fsync && !fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      hi_cnt    <= '0;
      cfg_q     <= CODE_32K;
      sig_frame <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (pulse_start) begin
        hi_cnt    <= CNT_W'(1);
        cfg_q     <= cfg_alg;
        sig_frame <= (MIN_WIDE <= 1);
      end else if (fsync) begin
        if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= CNT_ARM) sig_frame <= 1'b1;
      end
    end
  end

  assign cfg_norm = (cfg_q == CODE_24K || cfg_q == CODE_16K) ? cfg_q : CODE_32K;
  assign eff_alg  = (sig_frame && cfg_norm == CODE_32K) ? CODE_24K : cfg_norm;
endmodule

// File: rtl/cas_frame_classifier_chk.sv
module cas_frame_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fsync,
  input logic [2:0] eff_alg,
  input logic       sig_frame
);
  logic prev_fs;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_fs <= 1'b0;
    else        prev_fs <= fsync;
  end

  AST_WIDE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (fsync && prev_fs) |=> sig_frame); // R3
  AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (fsync && !prev_fs) |=> !sig_frame); // R4
  AST_QUIET_HOLDS_ALG: assert property (@(posedge clk) disable iff (!rst_n) !fsync |=> ($stable(eff_alg) && $stable(sig_frame))); // R5
  AST_FLAG_NEVER_32K: assert property (@(posedge clk) disable iff (!rst_n) sig_frame |-> (eff_alg != 3'b000)); // R6
  AST_LEGAL_ALG: assert property (@(posedge clk) disable iff (!rst_n) (eff_alg == 3'b000 || eff_alg == 3'b111 || eff_alg == 3'b101)); // R8
endmodule

bind cas_frame_classifier cas_frame_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .eff_alg(eff_alg), .sig_frame(sig_frame)
);

// File: tb/cas_frame_classifier_test.sv
module cas_frame_classifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [2:0] cfg_alg = 3'b000;
  logic [2:0] eff_alg;
  logic       sig_frame;

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  int         m_run = 0;
  bit         m_sig = 0, m_prev = 0;
  logic [2:0] m_lat = 3'b000;

  always #4 clk = ~clk;

  cas_frame_classifier uut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .cfg_alg(cfg_alg),
    .eff_alg(eff_alg), .sig_frame(sig_frame)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_sig = 0; m_prev = 0; m_lat = 3'b000;
    end else begin
      if (fsync) begin
        if (!m_prev) begin m_run = 1; m_sig = 0; m_lat = cfg_alg; end
        else begin m_run++; if (m_run >= 2) m_sig = 1; end
      end
      m_prev = fsync;
    end
  end

  function automatic logic [2:0] exp_alg();
    logic [2:0] base;
    base = (m_lat == 3'b111 || m_lat == 3'b101) ? m_lat : 3'b000;
    return (m_sig && base == 3'b000) ? 3'b111 : base;
  endfunction

  task automatic compare();
    n_run++;
    if (eff_alg !== exp_alg() || sig_frame !== m_sig) begin
      n_fail++;
      $display("FAIL %s: eff_alg=%b sig_frame=%b expected eff_alg=%b sig_frame=%b",
               tag, eff_alg, sig_frame, exp_alg(), m_sig);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
  endtask

  task automatic frame(input int width, input logic [2:0] cfg, input logic [2:0] mid_cfg, input string t);
    tag = t;
    cfg_alg = cfg;
    fsync = 1'b1;
    for (int i = 0; i < 16; i++) begin
      cycle();
      if (i == width - 1) fsync = 1'b0;
      if (i == 7) cfg_alg = mid_cfg;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    cycle(); cycle();
    n_run++;
    if (eff_alg !== 3'b000 || sig_frame !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: eff_alg=%b sig_frame=%b expected 000 0", eff_alg, sig_frame);
    end
    frame(1, 3'b000, 3'b000, "R2");
    frame(2, 3'b000, 3'b000, "R3_R6");
    frame(1, 3'b000, 3'b111, "R4");
    frame(1, 3'b111, 3'b000, "R5");
    frame(2, 3'b111, 3'b101, "R7");
    frame(2, 3'b101, 3'b000, "R7");
    frame(1, 3'b101, 3'b000, "R7");
    frame(2, 3'b011, 3'b000, "R8");
    frame(1, 3'b110, 3'b111, "R8");
    frame(3, 3'b000, 3'b101, "R9");
    frame(5, 3'b001, 3'b000, "R9");
    frame(1, 3'b000, 3'b000, "R4");
    frame(2, 3'b000, 3'b111, "R5");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule